// File: doc/BRIEF.md
# Control Endpoint Setup Mailbox

This block sits between the control endpoint of a USB function and an external master that sees it as a set of byte-wide registers. When the device receives a setup request that it cannot answer on its own, the host side hands the whole 8-byte setup packet to the mailbox in a single cycle. The mailbox then raises a setup interrupt and gives the bytes out one at a time through one register, whose internal pointer moves forward on every read.

The master can stall the request at any time by writing a non-zero value to the setup register. If the request has a data phase, the mailbox raises a buffer interrupt. For an IN request this happens when the IN buffer may be filled. For an OUT request it happens when the host side reports that a packet has arrived. IN data enters one byte per write to the data register. A write to the byte-count register commits the packet to the host side, which reads it through its own port and acknowledges it once it has been sent.

Register addresses: data 0x31, setup 0x32, byte count 0x33. The read data of the setup register appears on `reg_rdata` one clock after the read strobe.

Top module: `ep0_setup_mailbox`

## Requirements
- R1: A `setup_load` pulse sets `irq_setup` on the next clock. A read of register 0x32 clears it.
- R2: Successive reads of register 0x32 return setup bytes 0 to 7 in order, where byte 0 is `setup_pkt[7:0]`. Each byte is valid on `reg_rdata` one clock after its read strobe.
- R3: Reads of register 0x32 after the eighth return 0x00 and do not wrap. A new `setup_load` moves the read position back to byte 0.
- R4: A write of a non-zero value to register 0x32 sets `stall`. A write of zero leaves `stall` unchanged. A `setup_load` clears `stall`.
- R5: A setup packet whose byte 0 has bit 7 set (IN) and whose length field (byte 6 low, byte 7 high) is non-zero sets `buf_avail` and `irq_buf` on the next clock.
- R6: For an OUT request (byte 0 bit 7 clear) with a non-zero length, `setup_load` leaves `irq_buf` and `buf_avail` low. A later `host_out_arrive` pulse sets `irq_buf`.
- R7: Each write to register 0x31 while `buf_avail` is high stores the byte at the next buffer position, starting at 0 after a commit or a setup. The write clears `irq_buf`. The host side reads position `in_rd_addr` on `in_rd_data` one clock later.
- R8: A data write while 64 bytes are already held is dropped and sets `data_ovf`. A commit or a new setup clears `data_ovf`.
- R9: A write to register 0x33 while `buf_avail` is high commits the packet. On the next clock `in_pkt_valid` goes high, `in_len` equals the written value capped at 64, and `buf_avail` and `irq_buf` go low.
- R10: A `host_in_ack` pulse while `in_pkt_valid` is high clears `in_pkt_valid` and sets `buf_avail` and `irq_buf` on the next clock.
- R11: A data write while `buf_avail` is low is dropped. It neither stores nor advances the fill position, and it does not set `data_ovf`.
- R12: When `setup_load` falls in the same cycle as a read of 0x32, the read returns byte 0 of the incoming packet, the next read returns byte 1, and `irq_setup` stays set. When `setup_load` falls in the same cycle as a stall write, `stall` ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_load | input | 1 | Host side delivers a new setup packet |
| setup_pkt | input | 64 | Setup packet, byte 0 in bits 7:0 |
| host_out_arrive | input | 1 | OUT packet arrived from the host |
| host_in_ack | input | 1 | Committed IN packet was sent |
| in_rd_addr | input | 6 | Host-side IN buffer read position |
| in_rd_data | output | 8 | IN buffer byte, one clock after address |
| in_pkt_valid | output | 1 | A committed IN packet is waiting |
| in_len | output | 7 | Committed IN byte count |
| reg_wr | input | 1 | Master register write strobe |
| reg_rd | input | 1 | Master register read strobe |
| reg_addr | input | 8 | Master register address |
| reg_wdata | input | 8 | Master write data |
| reg_rdata | output | 8 | Master read data, one clock after the read |
| irq_setup | output | 1 | Setup interrupt |
| irq_buf | output | 1 | Buffer interrupt |
| buf_avail | output | 1 | IN buffer may be written |
| stall | output | 1 | Current request is stalled |
| data_ovf | output | 1 | A data byte beyond 64 was dropped |

## Verification
A new setup packet can arrive in the same cycle in which the master reads the setup register or writes a stall value to it. The bench drives `setup_load` together with a read strobe and checks that the returned byte and the following one come from the new packet, with the interrupt still set. It then drives `setup_load` together with a non-zero stall write and checks that `stall` reads low one clock later.

// File: rtl/ep0mb_pkg.sv
package ep0mb_pkg;
  localparam int DATA_W      = 8;
  localparam int SETUP_BYTES = 8;
  localparam int MAX_PKT     = 64;
  localparam int ADDR_W      = 8;

  localparam logic [ADDR_W-1:0] REG_DATA  = 8'h31;
  localparam logic [ADDR_W-1:0] REG_SETUP = 8'h32;
  localparam logic [ADDR_W-1:0] REG_COUNT = 8'h33;
endpackage

// File: rtl/ep0mb_setup_reg.sv
// Holds the setup packet and serves it one byte per read, saturating past the end.
module ep0mb_setup_reg #(
  parameter int DW = 8,
  parameter int SB = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [SB*DW-1:0] pkt,
  input  logic            rd,
  output logic [DW-1:0]   rd_byte
);
  localparam int IW  = $clog2(SB);
  localparam int SPW = $clog2(SB + 1);

  logic [DW-1:0]  bytes_in [SB];
  logic [DW-1:0]  store    [SB];
  logic [SPW-1:0] ptr;
  logic           in_range;

  for (genvar g = 0; g < SB; g++) begin : g_unpack
    assign bytes_in[g] = pkt[g*DW +: DW];
    always_ff @(posedge clk) begin
      if (rst) store[g] <= '0;
      else if (load) store[g] <= bytes_in[g];
    end
  end

  assign in_range = (ptr < SPW'(SB));

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (load) ptr <= rd ? SPW'(1) : '0;
    else if (rd && in_range) ptr <= ptr + SPW'(1);
  end

  always_comb begin
    if (load) rd_byte = bytes_in[0];
    else if (in_range) rd_byte = store[ptr[IW-1:0]];
    else rd_byte = '0;
  end
endmodule

// File: rtl/ep0mb_in_buf.sv
// IN packet buffer: one write port with fill pointer, registered read port.
module ep0mb_in_buf #(
  parameter int DW   = 8,
  parameter int MAXP = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    wr,
  input  logic                    avail,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(MAXP)-1:0] rd_addr,
  output logic [DW-1:0]           rd_data,
  output logic                    ovf
);
  localparam int AW = $clog2(MAXP);
  localparam int PW = $clog2(MAXP + 1);

  logic [DW-1:0] mem [MAXP];
  logic [PW-1:0] wptr;
  logic          full;
  logic          we;

  assign full = (wptr == PW'(MAXP));
  assign we   = wr && avail && !full;

  always_ff @(posedge clk) begin
    if (we) mem[wptr[AW-1:0]] <= wdata;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (we) wptr <= wptr + PW'(1);
      if (wr && avail && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/ep0mb_ctrl.sv
// Interrupt flags, buffer ownership, stall latch and committed length.
module ep0mb_ctrl #(
  parameter int DW   = 8,
  parameter int MAXP = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     setup_load,
  input  logic                     dir_in,
  input  logic                     has_data,
  input  logic                     setup_rd,
  input  logic                     stall_req,
  input  logic                     data_wr,
  input  logic                     count_wr,
  input  logic [DW-1:0]            count_val,
  input  logic                     out_arrive,
  input  logic                     in_ack,
  output logic                     commit_ok,
  output logic                     irq_setup,
  output logic                     irq_buf,
  output logic                     buf_avail,
  output logic                     stall,
  output logic                     pkt_valid,
  output logic [$clog2(MAXP+1)-1:0] in_len
);
  localparam int LW = $clog2(MAXP + 1);

  logic out_q;
  logic ack_ok;

  assign commit_ok = count_wr && buf_avail && !setup_load;
  assign ack_ok    = in_ack && pkt_valid && !setup_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_setup <= 1'b0;
      irq_buf   <= 1'b0;
      buf_avail <= 1'b0;
      stall     <= 1'b0;
      pkt_valid <= 1'b0;
      in_len    <= '0;
      out_q     <= 1'b0;
    end else if (setup_load) begin
      irq_setup <= 1'b1;
      irq_buf   <= dir_in && has_data;
      buf_avail <= dir_in && has_data;
      stall     <= 1'b0;
      pkt_valid <= 1'b0;
      out_q     <= !dir_in && has_data;
    end else begin
      if (setup_rd) irq_setup <= 1'b0;
      if (stall_req) stall <= 1'b1;
      if (commit_ok) begin
        buf_avail <= 1'b0;
        pkt_valid <= 1'b1;
        irq_buf   <= 1'b0;
        in_len    <= (count_val > DW'(MAXP)) ? LW'(MAXP) : LW'(count_val);
      end else if (ack_ok) begin
        buf_avail <= 1'b1;
        pkt_valid <= 1'b0;
        irq_buf   <= 1'b1;
      end else if (data_wr) begin
        irq_buf <= 1'b0;
      end else if (out_arrive && out_q) begin
        irq_buf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ep0_setup_mailbox.sv
module ep0_setup_mailbox
  import ep0mb_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int SB   = SETUP_BYTES,
  parameter int MAXP = MAX_PKT
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      setup_load,
  input  logic [SB*DW-1:0]          setup_pkt,
  input  logic                      host_out_arrive,
  input  logic                      host_in_ack,
  input  logic [$clog2(MAXP)-1:0]   in_rd_addr,
  output logic [DW-1:0]             in_rd_data,
  output logic                      in_pkt_valid,
  output logic [$clog2(MAXP+1)-1:0] in_len,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  output logic [DW-1:0]             reg_rdata,
  output logic                      irq_setup,
  output logic                      irq_buf,
  output logic                      buf_avail,
  output logic                      stall,
  output logic                      data_ovf
);
  logic          setup_rd, stall_req, data_wr, count_wr, commit_ok;
  logic          dir_in, has_data;
  logic [DW-1:0] setup_byte;

  assign setup_rd  = reg_rd && (reg_addr == REG_SETUP);
  assign stall_req = reg_wr && (reg_addr == REG_SETUP) && (reg_wdata != '0);
  assign data_wr   = reg_wr && (reg_addr == REG_DATA);
  assign count_wr  = reg_wr && (reg_addr == REG_COUNT);
  assign dir_in    = setup_pkt[DW-1];
  assign has_data  = (setup_pkt[SB*DW-1 -: 2*DW] != '0);

  ep0mb_setup_reg #(.DW(DW), .SB(SB)) setup_i (
    .clk(clk), .rst(rst), .load(setup_load), .pkt(setup_pkt),
    .rd(setup_rd), .rd_byte(setup_byte)
  );

  ep0mb_in_buf #(.DW(DW), .MAXP(MAXP)) buf_i (
    .clk(clk), .rst(rst), .clr(setup_load || commit_ok), .wr(data_wr),
    .avail(buf_avail), .wdata(reg_wdata), .rd_addr(in_rd_addr),
    .rd_data(in_rd_data), .ovf(data_ovf)
  );

  ep0mb_ctrl #(.DW(DW), .MAXP(MAXP)) ctrl_i (
    .clk(clk), .rst(rst), .setup_load(setup_load), .dir_in(dir_in),
    .has_data(has_data), .setup_rd(setup_rd), .stall_req(stall_req),
    .data_wr(data_wr), .count_wr(count_wr), .count_val(reg_wdata),
    .out_arrive(host_out_arrive), .in_ack(host_in_ack),
    .commit_ok(commit_ok), .irq_setup(irq_setup), .irq_buf(irq_buf),
    .buf_avail(buf_avail), .stall(stall), .pkt_valid(in_pkt_valid),
    .in_len(in_len)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= setup_rd ? setup_byte : '0;
  end
endmodule

// File: rtl/ep0mb_chk.sv
module ep0mb_chk
  import ep0mb_pkg::*;
#(
  parameter int MAXP = MAX_PKT
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      setup_load,
  input logic                      reg_wr,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [7:0]                reg_wdata,
  input logic                      host_in_ack,
  input logic                      irq_setup,
  input logic                      irq_buf,
  input logic                      buf_avail,
  input logic                      stall,
  input logic                      in_pkt_valid,
  input logic [$clog2(MAXP+1)-1:0] in_len
);
  a_r1_setup_irq: assert property (@(posedge clk) disable iff (rst)
    setup_load |=> irq_setup);

  a_r4_stall_clear: assert property (@(posedge clk) disable iff (rst)
    setup_load |=> !stall);

  a_r4_stall_set: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == REG_SETUP && reg_wdata != 8'h00 && !setup_load) |=> stall);

  a_r9_commit: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == REG_COUNT && buf_avail && !setup_load)
      |=> (in_pkt_valid && !buf_avail && !irq_buf));

  a_r9_len_cap: assert property (@(posedge clk) disable iff (rst)
    in_len <= ($clog2(MAXP+1))'(MAXP));

  a_r9_owner_excl: assert property (@(posedge clk) disable iff (rst)
    !(buf_avail && in_pkt_valid));

  a_r10_ack: assert property (@(posedge clk) disable iff (rst)
    (host_in_ack && in_pkt_valid && !setup_load)
      |=> (buf_avail && irq_buf && !in_pkt_valid));
endmodule

bind ep0_setup_mailbox ep0mb_chk #(.MAXP(MAXP)) chk_i (
  .clk(clk), .rst(rst), .setup_load(setup_load), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .host_in_ack(host_in_ack),
  .irq_setup(irq_setup), .irq_buf(irq_buf), .buf_avail(buf_avail),
  .stall(stall), .in_pkt_valid(in_pkt_valid), .in_len(in_len)
);

// File: tb/ep0_setup_mailbox_tb_top.sv
module ep0_setup_mailbox_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setup_load = 1'b0;
  logic [63:0] setup_pkt = '0;
  logic        host_out_arrive = 1'b0;
  logic        host_in_ack = 1'b0;
  logic [5:0]  in_rd_addr = '0;
  logic [7:0]  in_rd_data;
  logic        in_pkt_valid;
  logic [6:0]  in_len;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_setup, irq_buf, buf_avail, stall, data_ovf;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ep0_setup_mailbox dut_i (
    .clk(clk), .rst(rst), .setup_load(setup_load), .setup_pkt(setup_pkt),
    .host_out_arrive(host_out_arrive), .host_in_ack(host_in_ack),
    .in_rd_addr(in_rd_addr), .in_rd_data(in_rd_data),
    .in_pkt_valid(in_pkt_valid), .in_len(in_len), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_setup(irq_setup), .irq_buf(irq_buf),
    .buf_avail(buf_avail), .stall(stall), .data_ovf(data_ovf)
  );

  // IN packet, length 3: bytes C1 06 22 33 44 55 03 00
  localparam logic [63:0] PKT_IN  = 64'h0003_5544_3322_06C1;
  // OUT packet, length 2
  localparam logic [63:0] PKT_OUT = 64'h0002_0000_0000_0040;

  // vector: {rd, wr, addr, wdata, expected rdata}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h32, 8'h00, 8'hC1},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'h06},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'h22},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'h33},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'h44},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'h55},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'h03},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'h00}
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    reg_rd = 1'b1; reg_addr = a;
    cyc();
    reg_rd = 1'b0;
  endtask

  task automatic load(input logic [63:0] p);
    setup_load = 1'b1; setup_pkt = p;
    cyc();
    setup_load = 1'b0;
  endtask

  task automatic hread(input logic [5:0] a);
    in_rd_addr = a;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("reset irq_setup R1", irq_setup, 0);
    check("reset irq_buf R5", irq_buf, 0);
    check("reset buf_avail R5", buf_avail, 0);
    check("reset stall R4", stall, 0);
    check("reset pkt_valid R9", in_pkt_valid, 0);
    check("reset ovf R8", data_ovf, 0);

    load(PKT_IN);
    check("R1 irq after setup", irq_setup, 1);
    check("R5 buf_avail IN", buf_avail, 1);
    check("R5 irq_buf IN", irq_buf, 1);

    for (int i = 0; i < NV; i++) begin
      reg_rd = VEC[i][25]; reg_wr = VEC[i][24];
      reg_addr = VEC[i][23:16]; reg_wdata = VEC[i][15:8];
      cyc();
      reg_rd = 1'b0; reg_wr = 1'b0;
      if (VEC[i][25]) check(i < 8 ? "R2 setup byte order" : "R3 read past end",
                            reg_rdata, VEC[i][7:0]);
      if (i == 0) check("R1 irq cleared by read", irq_setup, 0);
    end

    wr(8'h32, 8'h00);
    check("R4 zero write no stall", stall, 0);
    wr(8'h32, 8'h55);
    check("R4 non-zero write stalls", stall, 1);

    wr(8'h31, 8'hA0);
    check("R7 data write clears irq_buf", irq_buf, 0);
    wr(8'h31, 8'hA1);
    wr(8'h31, 8'hA2);
    wr(8'h33, 8'd3);
    check("R9 pkt_valid", in_pkt_valid, 1);
    check("R9 in_len", in_len, 3);
    check("R9 buf_avail low", buf_avail, 0);
    hread(6'd0); check("R7 byte0", in_rd_data, 8'hA0);
    hread(6'd1); check("R7 byte1", in_rd_data, 8'hA1);
    hread(6'd2); check("R7 byte2", in_rd_data, 8'hA2);

    wr(8'h31, 8'hEE);
    check("R11 no ovf on dropped write", data_ovf, 0);
    host_in_ack = 1'b1; cyc(); host_in_ack = 1'b0;
    check("R10 pkt_valid cleared", in_pkt_valid, 0);
    check("R10 buf_avail set", buf_avail, 1);
    check("R10 irq_buf set", irq_buf, 1);
    wr(8'h31, 8'h77);
    wr(8'h33, 8'd200);
    check("R9 length capped", in_len, 64);
    hread(6'd0); check("R11 dropped byte not stored", in_rd_data, 8'h77);

    host_in_ack = 1'b1; cyc(); host_in_ack = 1'b0;
    for (int i = 0; i < 64; i++) wr(8'h31, 8'(i));
    check("R8 no ovf at 64", data_ovf, 0);
    wr(8'h31, 8'hFF);
    check("R8 ovf past 64", data_ovf, 1);
    wr(8'h33, 8'd64);
    check("R8 ovf cleared by commit", data_ovf, 0);
    check("R9 in_len 64", in_len, 64);
    hread(6'd63); check("R8 last byte kept", in_rd_data, 8'h3F);

    load(PKT_OUT);
    check("R4 setup clears stall", stall, 0);
    check("R6 no buf_avail OUT", buf_avail, 0);
    check("R6 no irq_buf at OUT setup", irq_buf, 0);
    rd(8'h32);
    check("R3 pointer reset", reg_rdata, 8'h40);
    host_out_arrive = 1'b1; cyc(); host_out_arrive = 1'b0;
    check("R6 irq_buf on OUT arrival", irq_buf, 1);

    setup_load = 1'b1; setup_pkt = PKT_IN; reg_rd = 1'b1; reg_addr = 8'h32;
    cyc();
    setup_load = 1'b0; reg_rd = 1'b0;
    check("R12 same-cycle read gives new byte0", reg_rdata, 8'hC1);
    check("R12 irq_setup kept", irq_setup, 1);
    rd(8'h32);
    check("R12 next read byte1", reg_rdata, 8'h06);
    wr(8'h32, 8'h11);
    check("R4 stall set again", stall, 1);
    setup_load = 1'b1; reg_wr = 1'b1; reg_addr = 8'h32; reg_wdata = 8'h22;
    cyc();
    setup_load = 1'b0; reg_wr = 1'b0;
    check("R12 setup beats stall write", stall, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule